// File: doc/BRIEF.md
# Zero-Crossing-Aligned Reference Deviation Unit

This block measures how far a sampled periodic waveform strays from a stored template of one period. It holds a 200-slot template. A host, or an averaging stage elsewhere on the chip, rewrites the template through a write-only load port at any time. For every accepted input sample, the unit picks one template slot, subtracts that slot's value from the sample, and presents the signed difference one clock later, together with the slot number that was used.

A rising zero crossing of the input itself sets the slot position. A crossing is a valid sample that is zero or positive, arriving when the previous valid sample was negative. Such a sample always uses slot 0. The following samples step through the template one slot per sample. If a period runs long, the slot pointer stops at the last slot and an overrun flag is raised. A short period realigns early. Because the pointer is restarted by the waveform rather than counting freely, the template stays in phase with the input even when the signal's frequency drifts.

The sequencer has three states:

- `ST_WAIT_SYNC` runs after reset, before any crossing has been seen. No output is produced in this state.
- `ST_TRACK` is normal stepping through the template.
- `ST_OVERRUN` means the pointer is held at the last slot.

The transitions are:

- LOCK: `ST_WAIT_SYNC` to `ST_TRACK` on the first crossing.
- SATURATE: `ST_TRACK` to `ST_OVERRUN` on a non-crossing sample while the pointer already sits on the last slot.
- REALIGN: `ST_TRACK` or `ST_OVERRUN` to `ST_TRACK` on any crossing.

Top module: `refcyc_dev`

## Requirements
- R1: A crossing is a valid sample whose sign bit (bit 15) is 0 while the previous valid sample had sign bit 1. That sample is compared with template slot 0, and `out_slot` reads 0. The first valid sample after reset is never a crossing.
- R2: Each valid sample that is not a crossing uses the slot one above the slot used by the previous valid sample. Cycles with `in_valid` low do not move the pointer.
- R3: A crossing returns the pointer to slot 0 from any slot, including slots below 199.
- R4: `out_dev` equals the sample minus the selected template value, computed as a 17-bit two's-complement result. This holds even at the extremes: 32767 − (−32768) = 65535 and −32768 − 32767 = −65535.
- R5: A write with `ld_we` high stores `ld_data` at `ld_addr` (addresses 0 to 199). Later samples that select that slot use the newest stored value.
- R6: When a load write hits the slot being selected in the same cycle, the deviation uses the value being written rather than the old contents.
- R7: A non-crossing sample arriving while the pointer is on slot 199 uses slot 199 again and raises `overrun`. `overrun` stays high until the next crossing, which clears it in the same cycle that slot 0 is reported.
- R8: After reset, `out_valid` stays low for every sample until the first crossing has been accepted.
- R9: `out_valid` goes high exactly one cycle after an accepted `in_valid`, and is low otherwise. Out of reset, `out_valid`, `out_dev`, `out_slot` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample |
| ld_we | input | 1 | Template write enable |
| ld_addr | input | 8 | Template slot to write |
| ld_data | input | 16 | Signed template value |
| out_valid | output | 1 | Deviation strobe |
| out_dev | output | 17 | Signed sample minus template value |
| out_slot | output | 8 | Template slot used for `out_dev` |
| overrun | output | 1 | Period longer than the template |

## Verification
The hardest state to reach is the overrun. It appears only after 200 consecutive non-crossing samples following a crossing, and it must then persist through a negative sample before the next crossing clears it. The bench drives a full period of positive samples, checking every slot on the way. It then adds one extra positive sample, then one negative sample, and finally a positive crossing. The same-cycle write to the selected slot is also reached only by timing: the test tracks the expected pointer so that the load address matches the slot the next sample will take.

// File: rtl/refcyc_pkg.sv
package refcyc_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_SYNC,
        ST_TRACK,
        ST_OVERRUN
    } seq_state_t;
endpackage

// File: rtl/refcyc_xdet.sv
module refcyc_xdet (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic smp_sign,
    output logic rise
);
    logic prev_neg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_neg_q <= 1'b0;
        else if (smp_valid)
            prev_neg_q <= smp_sign;
    end

    assign rise = smp_valid && prev_neg_q && !smp_sign;
endmodule

// File: rtl/refcyc_mem.sv
module refcyc_mem #(
    parameter int W     = 16,
    parameter int DEPTH = 200,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < AW'(DEPTH)))
            store[wr_addr] <= wr_data;
    end

    // A write to the slot being read this cycle wins over the stored word
    always_comb begin
        if (wr_en && (wr_addr == rd_addr))
            rd_data = wr_data;
        else
            rd_data = store[rd_addr];
    end
endmodule

// File: rtl/refcyc_seq.sv
module refcyc_seq
    import refcyc_pkg::*;
#(
    parameter int DEPTH = 200,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          rise,
    output logic [AW-1:0] rd_idx,
    output logic          accept,
    output logic          overrun
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] slot_q, slot_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SYNC;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rd_idx  = slot_q;
        accept  = 1'b0;
        if (smp_valid) begin
            if (rise) begin
                accept  = 1'b1;
                rd_idx  = '0;
                state_d = ST_TRACK;
            end else begin
                unique case (state_q)
                    ST_WAIT_SYNC: accept = 1'b0;
                    ST_TRACK: begin
                        accept = 1'b1;
                        if (slot_q == LAST) begin
                            rd_idx  = LAST;
                            state_d = ST_OVERRUN;
                        end else begin
                            rd_idx = slot_q + 1'b1;
                        end
                    end
                    ST_OVERRUN: begin
                        accept = 1'b1;
                        rd_idx = LAST;
                    end
                    default: state_d = ST_WAIT_SYNC;
                endcase
            end
        end
        slot_d  = accept ? rd_idx : slot_q;
        overrun = (state_q == ST_OVERRUN);
    end
endmodule

// File: rtl/refcyc_dev.sv
module refcyc_dev #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 200,
    parameter int IDX_W    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [SAMPLE_W-1:0]   in_sample,
    input  logic                  ld_we,
    input  logic [IDX_W-1:0]      ld_addr,
    input  logic [SAMPLE_W-1:0]   ld_data,
    output logic                  out_valid,
    output logic [SAMPLE_W:0]     out_dev,
    output logic [IDX_W-1:0]      out_slot,
    output logic                  overrun
);
    localparam int DW = SAMPLE_W + 1;

    logic                rise;
    logic                accept;
    logic [IDX_W-1:0]    rd_idx;
    logic [SAMPLE_W-1:0] ref_val;
    logic [DW-1:0]       diff;

    refcyc_xdet u_xdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (in_valid),
        .smp_sign  (in_sample[SAMPLE_W-1]),
        .rise      (rise)
    );

    refcyc_seq #(.DEPTH(DEPTH), .AW(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (in_valid),
        .rise      (rise),
        .rd_idx    (rd_idx),
        .accept    (accept),
        .overrun   (overrun)
    );

    refcyc_mem #(.W(SAMPLE_W), .DEPTH(DEPTH), .AW(IDX_W)) u_mem (
        .clk     (clk),
        .wr_en   (ld_we),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (rd_idx),
        .rd_data (ref_val)
    );

    assign diff = {in_sample[SAMPLE_W-1], in_sample} - {ref_val[SAMPLE_W-1], ref_val};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dev   <= '0;
            out_slot  <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_dev  <= diff;
                out_slot <= rd_idx;
            end
        end
    end
endmodule

// File: rtl/refcyc_dev_chk.sv
module refcyc_dev_chk #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 200,
    parameter int IDX_W    = $clog2(DEPTH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic                out_valid,
    input logic [IDX_W-1:0]    out_slot,
    input logic                overrun
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic             last_neg, locked, have_prev;
    logic [IDX_W-1:0] prev_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_neg  <= 1'b0;
            locked    <= 1'b0;
            have_prev <= 1'b0;
            prev_slot <= '0;
        end else begin
            if (in_valid) begin
                last_neg <= in_sample[SAMPLE_W-1];
                if (last_neg && !in_sample[SAMPLE_W-1])
                    locked <= 1'b1;
            end
            if (out_valid) begin
                have_prev <= 1'b1;
                prev_slot <= out_slot;
            end
        end
    end

    p_no_early_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> locked);

    p_one_cycle_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_prev && out_slot != '0)
            |-> (out_slot == prev_slot + 1'b1) || (out_slot == LAST && prev_slot == LAST));

    p_overrun_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> out_slot == LAST);

    p_overrun_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> out_valid);
endmodule

bind refcyc_dev refcyc_dev_chk #(
    .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_slot  (out_slot),
    .overrun   (overrun)
);

// File: tb/refcyc_dev_test.sv
`timescale 1ns/1ps
module refcyc_dev_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               ld_we = 1'b0;
    logic [7:0]         ld_addr = '0;
    logic signed [15:0] ld_data = '0;
    logic               out_valid;
    logic [16:0]        out_dev;
    logic [7:0]         out_slot;
    logic               overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int bref [200];

    always #10 clk = ~clk;

    refcyc_dev uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .out_valid(out_valid), .out_dev(out_dev), .out_slot(out_slot), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int s, input bit we, input int a, input int d);
        @(negedge clk);
        in_valid  = v;
        in_sample = 16'(s);
        ld_we     = we;
        ld_addr   = 8'(a);
        ld_data   = 16'(d);
        if (we) bref[a] = d;
        @(posedge clk);
        #1;
    endtask

    task automatic feed_chk(input int s, input int slot, input int ovr, input string tag);
        drive(1, s, 0, 0, 0);
        chk({tag, " out_valid"}, int'(out_valid), 1);
        chk({tag, " out_slot"}, int'(out_slot), slot);
        chk({tag, " out_dev"}, int'($signed(out_dev)), s - bref[slot]);
        chk({tag, " overrun"}, int'(overrun), ovr);
    endtask

    task automatic t_reset_and_load;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset out_valid", int'(out_valid), 0);
        chk("R9 reset out_dev", int'(out_dev), 0);
        chk("R9 reset out_slot", int'(out_slot), 0);
        chk("R9 reset overrun", int'(overrun), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++) drive(0, 0, 1, i, i * 10 - 1000);
    endtask

    task automatic t_lock;
        drive(1, 5, 0, 0, 0);
        chk("R8 prelock pos", int'(out_valid), 0);
        drive(1, 7, 0, 0, 0);
        chk("R8 prelock pos2", int'(out_valid), 0);
        drive(1, -3, 0, 0, 0);
        chk("R8 prelock neg", int'(out_valid), 0);
        feed_chk(4, 0, 0, "R1 first crossing");
    endtask

    task automatic t_advance;
        feed_chk(10, 1, 0, "R2 step1");
        feed_chk(20, 2, 0, "R2 step2");
        drive(0, 999, 0, 0, 0);
        chk("R9 idle no out_valid", int'(out_valid), 0);
        feed_chk(30, 3, 0, "R2 after gap");
        feed_chk(-5, 4, 0, "R2 negative sample");
        feed_chk(6, 0, 0, "R3 early wrap");
    endtask

    task automatic t_overrun;
        for (int k = 1; k < 200; k++) feed_chk(100, k, 0, "R7 period run");
        feed_chk(100, 199, 1, "R7 saturate");
        feed_chk(-50, 199, 1, "R7 hold");
        feed_chk(60, 0, 0, "R7 clear on crossing");
    endtask

    task automatic t_reload;
        drive(0, 0, 1, 1, 500);
        feed_chk(600, 1, 0, "R5 reloaded slot");
    endtask

    task automatic t_bypass;
        drive(1, 300, 1, 2, 77);
        chk("R6 bypass out_slot", int'(out_slot), 2);
        chk("R6 bypass out_dev", int'($signed(out_dev)), 223);
    endtask

    task automatic t_extremes;
        drive(0, 0, 1, 3, -32768);
        drive(0, 0, 1, 4, 32767);
        feed_chk(32767, 3, 0, "R4 max positive");
        chk("R4 value", int'($signed(out_dev)), 65535);
        feed_chk(-32768, 4, 0, "R4 max negative");
        chk("R4 value neg", int'($signed(out_dev)), -65535);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_and_load();
        t_lock();
        t_advance();
        t_overrun();
        t_reload();
        t_bypass();
        t_extremes();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule